// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Byte Receiver

This block takes one asynchronous serial line and turns 8N1 frames into bytes: one start bit, eight data bits, one stop bit and no parity. It does not make its own baud timing. A tick-enable input must pulse once per oversampling slot. That is the system clock divided by eight times the baud rate, which gives eight ticks per bit. Before anything looks at the line, it passes through a two-flop synchronizer. The line rests high through a pull-up, so a high level is the idle state.

Once the synchronized line is seen low on a tick, a frame has started. The first data bit is sampled twelve ticks later, in the middle of that bit. Each further bit is sampled eight ticks after the one before it. Bits come in least significant first and enter the byte from the top. The stop bit is sampled last.

- **Good stop (high):** the byte goes out with a one-cycle strobe. The receiver looks for the next start on the very next tick, so a transmitter running slightly fast is still received.
- **Bad stop (low):** the stop bit is low on a framing error or a break. The byte is dropped and a sticky fault flag is raised. The receiver then waits for the line to go high before it looks for another start.

Top module: `uart8x_rx`

## Requirements
- R1: While reset is held, rx_byte is 0, rx_strobe is 0 and rx_fault is 0.
- R2: A frame starts on the first tick where the synchronized line is low. Data bit i (i = 0..7) is sampled on the tick 12 + 8*i ticks after that start tick, and the stop bit on the tick 76 ticks after it.
- R3: rx_byte bit i holds the i-th data bit after the start bit (least significant bit first).
- R4: On a high stop sample, rx_strobe is 1 for exactly one clock, in the clock right after the stop-sample tick. rx_byte takes the new byte in that same clock and changes at no other time.
- R5: After a high stop sample, a start bit is accepted on the very next tick. A frame whose stop bit lasts only 5 ticks, followed at once by the next start bit, yields both bytes.
- R6: On a low stop sample, no strobe is given, no byte is delivered, and rx_fault becomes 1 in the clock right after the stop-sample tick.
- R7: After a low stop sample, no new frame starts until the line has been seen high on a tick. A line held low (a break) produces exactly one fault and no byte.
- R8: rx_fault stays 1 until err_clear is 1 on a clock edge, and is 0 in the clock after that edge. If err_clear is 1 on the same edge as a new fault, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Asynchronous serial input, idle high |
| tick_en | input | 1 | Oversampling enable, eight pulses per bit |
| err_clear | input | 1 | Clears the sticky fault flag |
| rx_byte | output | DATA_BITS | Last byte received with a good stop bit |
| rx_strobe | output | 1 | One-clock pulse when rx_byte is new |
| rx_fault | output | 1 | Sticky framing-error or break flag |

## Verification
The timing is fixed relative to the start tick:
- The strobe, the new byte and the fault all appear one clock after the stop-sample tick, which is 76 ticks after the start tick.
- The fault is 0 one clock after a clear.

The bench changes the line only on the falling clock edge right after a tick. The synchronizer has settled before the next tick, so the start is taken on that next tick. A monitor on the falling edge records the tick count at every strobe and at every rise of the fault flag, and compares it with the start count plus 77. Queue and flag checks are made only after at least one further tick, so the monitor has already seen the result being checked.

// File: rtl/uart8x_pkg.sv
package uart8x_pkg;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_DATA = 2'd1,
    RX_STOP = 2'd2,
    RX_HOLD = 2'd3
  } rx_state_t;

  function automatic int first_wait(input int osr);
    return osr + osr / 2 - 1;
  endfunction

endpackage

// File: rtl/uart8x_sync.sv
module uart8x_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] ff;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) ff <= RESET_VAL;
        else     ff <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) ff <= {STAGES{RESET_VAL}};
        else     ff <= {ff[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = ff[STAGES-1];

endmodule

// File: rtl/uart8x_bittimer.sv
module uart8x_bittimer #(
  parameter int OSR = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic load_first,
  input  logic load_next,
  output logic expire
);

  localparam int FIRST = uart8x_pkg::first_wait(OSR);
  localparam int NEXT  = OSR - 1;
  localparam int CNT_W = $clog2(FIRST + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (tick) begin
      if (load_first)      cnt <= CNT_W'(FIRST);
      else if (load_next)  cnt <= CNT_W'(NEXT);
      else if (cnt != '0)  cnt <= cnt - 1'b1;
    end
  end

  assign expire = tick && (cnt == '0);

endmodule

// File: rtl/uart8x_shifter.sv
module uart8x_shifter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             bit_in,
  output logic [WIDTH-1:0] word
);

  generate
    if (WIDTH == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst)           word <= '0;
        else if (shift_en) word <= bit_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst)           word <= '0;
        else if (shift_en) word <= {bit_in, word[WIDTH-1:1]};
      end
    end
  endgenerate

endmodule

// File: rtl/uart8x_sticky.sv
module uart8x_sticky (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);

  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (clr) q <= 1'b0;
    else if (set) q <= 1'b1;
  end

endmodule

// File: rtl/uart8x_rx.sv
module uart8x_rx #(
  parameter int DATA_BITS   = 8,
  parameter int OSR         = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 line_in,
  input  logic                 tick_en,
  input  logic                 err_clear,
  output logic [DATA_BITS-1:0] rx_byte,
  output logic                 rx_strobe,
  output logic                 rx_fault
);

  import uart8x_pkg::*;

  localparam int BIT_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_BITS - 1);

  rx_state_t            state;
  logic [BIT_W-1:0]     bit_cnt;
  logic                 line_s;
  logic                 expire;
  logic                 detect;
  logic                 samp_data;
  logic                 samp_stop;
  logic                 stop_ok;
  logic                 stop_bad;
  logic [DATA_BITS-1:0] shift_word;

  uart8x_sync #(
    .STAGES    (SYNC_STAGES),
    .RESET_VAL (1'b1)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (line_in),
    .q   (line_s)
  );

  assign detect    = tick_en && (state == RX_IDLE) && !line_s;
  assign samp_data = expire && (state == RX_DATA);
  assign samp_stop = expire && (state == RX_STOP);
  assign stop_ok   = samp_stop && line_s;
  assign stop_bad  = samp_stop && !line_s;

  uart8x_bittimer #(
    .OSR (OSR)
  ) u_timer (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick_en),
    .load_first (detect),
    .load_next  (samp_data),
    .expire     (expire)
  );

  uart8x_shifter #(
    .WIDTH (DATA_BITS)
  ) u_shift (
    .clk      (clk),
    .rst      (rst),
    .shift_en (samp_data),
    .bit_in   (line_s),
    .word     (shift_word)
  );

  uart8x_sticky u_fault (
    .clk (clk),
    .rst (rst),
    .set (stop_bad),
    .clr (err_clear),
    .q   (rx_fault)
  );

  // frame sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RX_IDLE;
      bit_cnt <= '0;
    end else begin
      case (state)
        RX_IDLE: begin
          if (detect) begin
            state   <= RX_DATA;
            bit_cnt <= '0;
          end
        end
        RX_DATA: begin
          if (samp_data) begin
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST_BIT) state <= RX_STOP;
          end
        end
        RX_STOP: begin
          if (samp_stop) state <= line_s ? RX_IDLE : RX_HOLD;
        end
        RX_HOLD: begin
          if (tick_en && line_s) state <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  // registered byte output
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_strobe <= 1'b0;
      rx_byte   <= '0;
    end else begin
      rx_strobe <= stop_ok;
      if (stop_ok) rx_byte <= shift_word;
    end
  end

endmodule

// File: rtl/uart8x_rx_chk.sv
module uart8x_rx_chk #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 tick_en,
  input logic                 err_clear,
  input logic [DATA_BITS-1:0] rx_byte,
  input logic                 rx_strobe,
  input logic                 rx_fault
);

  // R4: strobe is a single clock wide
  a_r4_strobe_one_cycle: assert property (@(posedge clk) disable iff (rst)
    rx_strobe |=> !rx_strobe);

  // R4: strobe follows a tick
  a_r4_strobe_after_tick: assert property (@(posedge clk) disable iff (rst)
    rx_strobe |-> $past(tick_en));

  // R4: byte only changes together with the strobe
  a_r4_byte_held: assert property (@(posedge clk) disable iff (rst)
    !rx_strobe |-> $stable(rx_byte));

  // R6: a fault never comes with a delivered byte
  a_r6_fault_without_byte: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_fault) |-> !rx_strobe);

  // R6: fault rises right after a tick
  a_r6_fault_after_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_fault) |-> $past(tick_en));

  // R8: sticky until cleared
  a_r8_fault_sticky: assert property (@(posedge clk) disable iff (rst)
    (rx_fault && !err_clear) |=> rx_fault);

  // R8: clear wins
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (rst)
    err_clear |=> !rx_fault);

endmodule

bind uart8x_rx uart8x_rx_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick_en   (tick_en),
  .err_clear (err_clear),
  .rx_byte   (rx_byte),
  .rx_strobe (rx_strobe),
  .rx_fault  (rx_fault)
);

// File: tb/uart8x_rx_test.sv
`timescale 1ns/1ps
module uart8x_rx_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line = 1'b1;
  logic tick = 1'b0;
  logic clr = 1'b0;
  logic [7:0] byte_o;
  logic strobe;
  logic fault;

  uart8x_rx #(.DATA_BITS(8), .OSR(8), .SYNC_STAGES(2)) uut (
    .clk       (clk),
    .rst       (rst),
    .line_in   (line),
    .tick_en   (tick),
    .err_clear (clr),
    .rx_byte   (byte_o),
    .rx_strobe (strobe),
    .rx_fault  (fault)
  );

  always #2 clk = ~clk;

  int unsigned phase = 0;
  int unsigned tick_cnt = 0;
  always @(negedge clk) begin
    phase = (phase + 1) % 4;
    tick  = (phase == 0);
  end
  always @(posedge clk) if (tick) tick_cnt <= tick_cnt + 1;

  logic [7:0]  got_q[$];
  int unsigned got_t[$];
  logic [7:0]  exp_q[$];
  int unsigned exp_t[$];
  int unsigned dbl = 0, fault_cycles = 0, fault_rises = 0, fault_rise_t = 0;
  bit strobe_prev = 0, fault_prev = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (strobe) begin
        got_q.push_back(byte_o);
        got_t.push_back(tick_cnt);
        if (strobe_prev) dbl++;
      end
      if (fault) fault_cycles++;
      if (fault && !fault_prev) begin
        fault_rises++;
        fault_rise_t = tick_cnt;
      end
      strobe_prev = strobe;
      fault_prev  = fault;
    end
  end

  int total = 0, bad = 0;
  bit done = 0;

  task automatic check_eq(input string req, input string what,
                          input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    int unsigned target;
    target = tick_cnt + n;
    while (tick_cnt < target) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input bit good,
                            input int stop_ticks, output int unsigned c);
    c = tick_cnt;
    line = 1'b0;
    wait_ticks(8);
    for (int i = 0; i < 8; i++) begin
      line = b[i];
      wait_ticks(8);
    end
    line = good;
    if (good) begin
      exp_q.push_back(b);
      exp_t.push_back(c + 77);
    end
    wait_ticks(stop_ticks);
  endtask

  task automatic compare_queue(input string req);
    wait_ticks(1);
    check_eq(req, "byte count", got_q.size(), exp_q.size());
    while (got_q.size() > 0 && exp_q.size() > 0) begin
      logic [7:0]  gb, eb;
      int unsigned gt, et;
      gb = got_q.pop_front(); eb = exp_q.pop_front();
      gt = got_t.pop_front(); et = exp_t.pop_front();
      check_eq(req, "byte value", gb, eb);
      check_eq("R2", "strobe tick", gt, et);
    end
    got_q.delete(); got_t.delete(); exp_q.delete(); exp_t.delete();
  endtask

  task automatic clear_fault();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    @(negedge clk);
    check_eq("R8", "fault after clear", fault, 0);
    wait_ticks(1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int unsigned c;
    int unsigned rises0, cycles0;
    void'($urandom(1234));
    repeat (4) @(negedge clk);
    check_eq("R1", "byte in reset", byte_o, 0);
    check_eq("R1", "strobe in reset", strobe, 0);
    check_eq("R1", "fault in reset", fault, 0);
    rst = 1'b0;
    wait_ticks(3);

    // directed frames, R2 R3 R4
    send_frame(8'hA5, 1, 8, c);
    line = 1'b1; wait_ticks(4);
    compare_queue("R4");
    send_frame(8'h01, 1, 8, c);
    line = 1'b1; wait_ticks(2);
    send_frame(8'h80, 1, 8, c);
    line = 1'b1; wait_ticks(2);
    compare_queue("R3");

    // back-to-back with short stop, R5
    send_frame(8'h3C, 1, 5, c);
    send_frame(8'hC3, 1, 5, c);
    send_frame(8'h96, 1, 5, c);
    line = 1'b1; wait_ticks(3);
    compare_queue("R5");

    // bad stop, R6 and sticky R8
    rises0 = fault_rises;
    send_frame(8'h5A, 0, 8, c);
    line = 1'b1; wait_ticks(3);
    check_eq("R6", "bytes after bad stop", got_q.size(), 0);
    check_eq("R6", "fault set", fault, 1);
    check_eq("R6", "fault rise count", fault_rises, rises0 + 1);
    check_eq("R6", "fault tick", fault_rise_t, c + 77);
    wait_ticks(20);
    check_eq("R8", "fault still set", fault, 1);
    clear_fault();

    // break, R7
    rises0 = fault_rises;
    line = 1'b0;
    wait_ticks(150);
    check_eq("R7", "fault on break", fault, 1);
    clear_fault();
    wait_ticks(100);
    check_eq("R7", "fault while line low", fault, 0);
    check_eq("R7", "one fault per break", fault_rises, rises0 + 1);
    check_eq("R7", "bytes during break", got_q.size(), 0);
    line = 1'b1; wait_ticks(3);
    send_frame(8'hE7, 1, 8, c);
    line = 1'b1; wait_ticks(3);
    compare_queue("R7");

    // clear priority, R8
    cycles0 = fault_cycles;
    clr = 1'b1;
    send_frame(8'h11, 0, 8, c);
    line = 1'b1; wait_ticks(3);
    clr = 1'b0;
    wait_ticks(2);
    check_eq("R8", "fault cycles with clear held", fault_cycles, cycles0);
    check_eq("R8", "fault after clear priority", fault, 0);

    // random mix
    for (int k = 0; k < 24; k++) begin
      logic [7:0] b;
      bit good;
      b    = 8'($urandom_range(0, 255));
      good = ($urandom_range(0, 4) != 0);
      if (good) begin
        send_frame(b, 1, $urandom_range(5, 12), c);
      end else begin
        compare_queue("R3");
        send_frame(b, 0, 8, c);
        line = 1'b1;
        wait_ticks($urandom_range(1, 6));
        check_eq("R6", "random bad stop fault", fault, 1);
        check_eq("R6", "random bad stop tick", fault_rise_t, c + 77);
        clear_fault();
      end
    end
    line = 1'b1; wait_ticks(3);
    compare_queue("R3");
    check_eq("R4", "double-wide strobes", dbl, 0);

    finish_run();
  end

endmodule